// File: doc/BRIEF.md
# Dual-Clock Alternating Scanline Buffer

This block separates pixel rendering from display scan-out. A render engine on the system clock writes the 8-bit palette indices of the next scanline into one of two line memories. Meanwhile the display logic on the independent pixel clock reads the other memory one pixel per active cycle and passes each index on to the palette lookup. Each memory has one write port on the system clock and one read port on the pixel clock.

At the end of every active line the display side swaps its read memory at once and sends a boundary event through a toggle synchronizer into the system domain. There the render side moves its writes to the other memory. The render side raises a completion flag once the final pixel of its line has been written. If that flag is still low when a boundary arrives, a sticky underrun bit is set, because the display is about to show a line that was only partly drawn.

Top module: `scanline_pingpong`

## Requirements
- R1: After reset the render side writes buffer 0 (`wr_bank`=0), the display side reads buffer 1 (`rd_bank`=1), and `line_done`, `underrun` and `pix_valid` are all 0.
- R2: A system-clock cycle with `wr_en`=1 and `wr_addr` < LINE_LEN stores `wr_data` at that address in buffer `wr_bank`. A write whose address is LINE_LEN or more stores nothing and does not set `line_done`.
- R3: `line_done` goes to 1 on the system edge that accepts a write to address LINE_LEN-1. It returns to 0 on the edge that takes in a line boundary.
- R4: A `line_end` pulse flips `rd_bank` on the next pixel-clock edge and sets the read address back to 0.
- R5: Each `line_end` reaches the system domain through SYNC_STAGES synchronizer flops. `wr_bank` flips exactly once per boundary, no earlier than SYNC_STAGES system edges after the pixel-side toggle, and stays stable at all other times.
- R6: Each pixel cycle with `active`=1 reads the current address and then advances it. The stored index appears on `pix_idx` one pixel cycle later, with `pix_valid`=1. The address stops at LINE_LEN-1, so extra active cycles repeat the final pixel.
- R7: `pix_idx` always comes from buffer `rd_bank`. Writes into the other buffer do not change the pixels being shown.
- R8: If a boundary arrives in the system domain and no write to address LINE_LEN-1 has completed since the previous boundary, `underrun` is set to 1 and stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System (render) clock |
| sys_rst_n | input | 1 | Active-low reset, system domain |
| wr_en | input | 1 | Render write strobe |
| wr_addr | input | $clog2(LINE_LEN) | Pixel position within the line being rendered |
| wr_data | input | 8 | Palette index to store |
| wr_bank | output | 1 | Buffer currently being rendered |
| line_done | output | 1 | Last pixel of the current line has been written |
| underrun | output | 1 | Sticky: a boundary arrived before the line was complete |
| pix_clk | input | 1 | Pixel (display) clock |
| pix_rst_n | input | 1 | Active-low reset, pixel domain |
| active | input | 1 | Display is in the active part of the line |
| line_end | input | 1 | One-cycle pulse at the end of an active line |
| rd_bank | output | 1 | Buffer currently being displayed |
| pix_idx | output | 8 | Palette index for the current pixel |
| pix_valid | output | 1 | `pix_idx` holds a freshly read pixel |

## Verification
The bench fills each buffer with its own pattern and then reads it back while the opposite buffer is being overwritten. A design that picked the read memory from the write select would show the new pattern in place of the old one. It drives more active cycles than the line holds, which catches an address that wraps or runs past the end when it should hold at the last pixel. It also samples `wr_bank` right after a boundary and again once the synchronizer has settled, so a swap that skips synchronization or never arrives is reported. Partial lines and out-of-range writes then check that the underrun bit latches and stays set, and that a stray address cannot fake a complete line.

// File: rtl/slb_pkg.sv
package slb_pkg;
  localparam int unsigned PIX_W = 8;

  // Next read position: advance, but hold on the final pixel of the line.
  function automatic int unsigned next_rd_pos(int unsigned pos, int unsigned len);
    return (pos + 1 < len) ? pos + 1 : pos;
  endfunction

  // A write lands only inside the line.
  function automatic logic pos_in_line(int unsigned pos, int unsigned len);
    return pos < len;
  endfunction

  // Does a write strobe target the given bank?
  function automatic logic bank_write(logic ok, logic sel, int unsigned bank);
    return ok && (int'(sel) == int'(bank));
  endfunction
endpackage

// File: rtl/slb_bank.sv
module slb_bank #(
  parameter int unsigned DEPTH = 640,
  parameter int unsigned DW    = 8,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/slb_toggle_sync.sv
module slb_toggle_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic src_pulse,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic dst_pulse
);
  logic              flag;
  logic [STAGES-1:0] chain;
  logic              seen;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) flag <= 1'b0;
    else            flag <= flag ^ src_pulse;
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      chain <= '0;
      seen  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], flag};
      seen  <= chain[STAGES-1];
    end
  end

  assign dst_pulse = chain[STAGES-1] ^ seen;
endmodule

// File: rtl/slb_render_ctl.sv
module slb_render_ctl
  import slb_pkg::*;
#(
  parameter int unsigned LINE_LEN = 640,
  parameter int unsigned AW       = $clog2(LINE_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          swap_evt,
  output logic          wr_ok,
  output logic          wr_bank,
  output logic          line_done,
  output logic          underrun
);
  localparam logic [AW-1:0] LAST_POS = AW'(LINE_LEN - 1);

  logic last_write;

  assign wr_ok      = wr_en && pos_in_line(int'(wr_addr), LINE_LEN);
  assign last_write = wr_ok && (wr_addr == LAST_POS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_bank   <= 1'b0;
      line_done <= 1'b0;
      underrun  <= 1'b0;
    end else if (swap_evt) begin
      wr_bank   <= ~wr_bank;
      line_done <= 1'b0;
      if (!(line_done || last_write)) underrun <= 1'b1;
    end else if (last_write) begin
      line_done <= 1'b1;
    end
  end
endmodule

// File: rtl/slb_scan_rd.sv
module slb_scan_rd
  import slb_pkg::*;
#(
  parameter int unsigned LINE_LEN = 640,
  parameter int unsigned AW       = $clog2(LINE_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          line_end,
  output logic          rd_bank,
  output logic [AW-1:0] rd_addr,
  output logic          rd_sel_q,
  output logic          pix_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bank   <= 1'b1;
      rd_addr   <= '0;
      rd_sel_q  <= 1'b1;
      pix_valid <= 1'b0;
    end else begin
      pix_valid <= active;
      if (active) rd_sel_q <= rd_bank;
      if (line_end) begin
        rd_bank <= ~rd_bank;
        rd_addr <= '0;
      end else if (active) begin
        rd_addr <= AW'(next_rd_pos(int'(rd_addr), LINE_LEN));
      end
    end
  end
endmodule

// File: rtl/scanline_pingpong.sv
module scanline_pingpong
  import slb_pkg::*;
#(
  parameter int unsigned LINE_LEN    = 640,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned AW         = $clog2(LINE_LEN)
) (
  input  logic             sys_clk,
  input  logic             sys_rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [PIX_W-1:0] wr_data,
  output logic             wr_bank,
  output logic             line_done,
  output logic             underrun,
  input  logic             pix_clk,
  input  logic             pix_rst_n,
  input  logic             active,
  input  logic             line_end,
  output logic             rd_bank,
  output logic [PIX_W-1:0] pix_idx,
  output logic             pix_valid
);
  logic             swap_evt;
  logic             wr_ok;
  logic [AW-1:0]    rd_addr;
  logic             rd_sel_q;
  logic [PIX_W-1:0] bank_q [2];

  slb_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .src_clk(pix_clk), .src_rst_n(pix_rst_n), .src_pulse(line_end),
    .dst_clk(sys_clk), .dst_rst_n(sys_rst_n), .dst_pulse(swap_evt)
  );

  slb_render_ctl #(.LINE_LEN(LINE_LEN), .AW(AW)) u_wctl (
    .clk(sys_clk), .rst_n(sys_rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .swap_evt(swap_evt), .wr_ok(wr_ok), .wr_bank(wr_bank),
    .line_done(line_done), .underrun(underrun)
  );

  slb_scan_rd #(.LINE_LEN(LINE_LEN), .AW(AW)) u_rctl (
    .clk(pix_clk), .rst_n(pix_rst_n), .active(active), .line_end(line_end),
    .rd_bank(rd_bank), .rd_addr(rd_addr), .rd_sel_q(rd_sel_q),
    .pix_valid(pix_valid)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    slb_bank #(.DEPTH(LINE_LEN), .DW(PIX_W), .AW(AW)) u_mem (
      .wclk(sys_clk), .we(bank_write(wr_ok, wr_bank, b)),
      .waddr(wr_addr), .wdata(wr_data),
      .rclk(pix_clk), .re(active && (rd_bank == 1'(b))),
      .raddr(rd_addr), .rdata(bank_q[b])
    );
  end

  assign pix_idx = bank_q[rd_sel_q];
endmodule

// File: rtl/slb_chk.sv
module slb_chk #(
  parameter int unsigned LINE_LEN = 640,
  localparam int unsigned AW      = $clog2(LINE_LEN)
) (
  input logic          sys_clk,
  input logic          sys_rst_n,
  input logic          pix_clk,
  input logic          pix_rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          swap_evt,
  input logic          wr_bank,
  input logic          line_done,
  input logic          underrun,
  input logic          line_end,
  input logic          rd_bank,
  input logic [AW-1:0] rd_addr
);
  // R3
  done_set_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (wr_en && wr_addr == AW'(LINE_LEN - 1) && !swap_evt) |=> line_done);
  // R3
  done_clr_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    swap_evt |=> !line_done);
  // R5
  wr_flip_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    swap_evt |=> wr_bank != $past(wr_bank));
  // R5
  wr_hold_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    !swap_evt |=> $stable(wr_bank));
  // R8
  underrun_sticky_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    underrun |=> underrun);
  // R4
  rd_flip_chk: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
    line_end |=> (rd_bank != $past(rd_bank)) && rd_addr == '0);
  // R6
  rd_range_chk: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
    int'(rd_addr) < LINE_LEN);
endmodule

bind scanline_pingpong slb_chk #(.LINE_LEN(LINE_LEN)) u_chk (
  .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .pix_clk(pix_clk),
  .pix_rst_n(pix_rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .swap_evt(swap_evt), .wr_bank(wr_bank), .line_done(line_done),
  .underrun(underrun), .line_end(line_end), .rd_bank(rd_bank),
  .rd_addr(rd_addr)
);

// File: tb/sim_scanline_pingpong.sv
module sim_scanline_pingpong;
  localparam int SYS_PERIOD = 10;
  localparam int PIX_PERIOD = 26;
  localparam int L          = 12;
  localparam int AW         = $clog2(L);

  logic sys_clk = 0, pix_clk = 0;
  logic sys_rst_n = 0, pix_rst_n = 0;
  logic wr_en = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic active = 0, line_end = 0;
  logic wr_bank, line_done, underrun, rd_bank, pix_valid;
  logic [7:0] pix_idx;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(SYS_PERIOD/2) sys_clk = ~sys_clk;
  always #(PIX_PERIOD/2) pix_clk = ~pix_clk;

  scanline_pingpong #(.LINE_LEN(L), .SYNC_STAGES(2)) u0 (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_bank(wr_bank), .line_done(line_done),
    .underrun(underrun), .pix_clk(pix_clk), .pix_rst_n(pix_rst_n),
    .active(active), .line_end(line_end), .rd_bank(rd_bank),
    .pix_idx(pix_idx), .pix_valid(pix_valid)
  );

  function automatic logic [7:0] pat(int tag, int i);
    return 8'((tag * 37 + i * 5 + 3) & 255);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_px(int pos, int tag);
    @(negedge sys_clk);
    wr_en = 1; wr_addr = AW'(pos); wr_data = pat(tag, pos);
    @(negedge sys_clk);
    wr_en = 0;
  endtask

  task automatic fill(int upto, int tag);
    for (int i = 0; i < upto; i++) write_px(i, tag);
  endtask

  // Pulse line_end; check the pixel side at once and the render side after settling.
  task automatic boundary(logic exp_rd, logic exp_wr);
    logic wr_before;
    wr_before = wr_bank;
    @(negedge pix_clk); line_end = 1;
    @(negedge pix_clk); line_end = 0;
    chk("R4 rd_bank flips on line_end", rd_bank, exp_rd);
    chk("R5 wr_bank not yet flipped before sync", wr_bank, wr_before);
    repeat (8) @(negedge sys_clk);
    chk("R5 wr_bank flips after sync", wr_bank, exp_wr);
    chk("R3 line_done cleared on boundary", line_done, 0);
  endtask

  // Read n pixels; entries below split carry tag_lo, the rest tag_hi.
  task automatic read_line(int n, int tag_lo, int tag_hi, int split, string req);
    @(negedge pix_clk); active = 1;
    for (int i = 0; i < n; i++) begin
      int j;
      @(negedge pix_clk);
      if (i == n - 1) active = 0;
      j = (i < L) ? i : L - 1;
      chk({req, " pixel value"}, pix_idx, pat(j < split ? tag_lo : tag_hi, j));
      chk("R6 pix_valid during read", pix_valid, 1);
    end
    @(negedge pix_clk);
    chk("R6 pix_valid low when idle", pix_valid, 0);
  endtask

  task automatic t_reset;
    chk("R1 wr_bank", wr_bank, 0);
    chk("R1 rd_bank", rd_bank, 1);
    chk("R1 line_done", line_done, 0);
    chk("R1 underrun", underrun, 0);
    chk("R1 pix_valid", pix_valid, 0);
  endtask

  task automatic t_first_line;
    fill(L - 1, 1);
    chk("R3 line_done low before last pixel", line_done, 0);
    write_px(L - 1, 1);
    chk("R3 line_done after last pixel", line_done, 1);
    boundary(1'b0, 1'b1);
    chk("R8 no underrun on complete line", underrun, 0);
  endtask

  task automatic t_isolation;
    fill(L, 2);
    read_line(L, 1, 1, L, "R7 shown buffer unaffected by other writes");
    boundary(1'b1, 1'b0);
    read_line(L + 4, 2, 2, L, "R6 address holds at end, R2 second buffer");
  endtask

  task automatic t_partial_and_range;
    write_px(L + 1, 3);
    chk("R2 out-of-range write leaves line_done low", line_done, 0);
    fill(L / 2, 3);
    chk("R3 partial line not done", line_done, 0);
    boundary(1'b0, 1'b1);
    chk("R8 underrun after partial line", underrun, 1);
    read_line(L, 3, 1, L / 2, "R2 partial overwrite over old contents");
    fill(L, 4);
    boundary(1'b1, 1'b0);
    chk("R8 underrun stays set", underrun, 1);
    read_line(L, 4, 4, L, "R7 full line after underrun");
  endtask

  initial begin
    repeat (3) @(negedge pix_clk);
    sys_rst_n = 1; pix_rst_n = 1;
    @(negedge sys_clk);
    t_reset();
    t_first_line();
    t_isolation();
    t_partial_and_range();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(SYS_PERIOD * 100000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule